// File: doc/BRIEF.md
# Dual-Path ADC Test Pattern Generator

This block sits on a converter's output data path and can replace live samples with synthetic test data. It has two pattern engines. The raw engine can stand in for the unprocessed converter samples when the signal-processing chain is switched off. The down-converter engine can stand in for the down-converter's output whenever the down-converter is in use. If signal processing is on and the down-converter is unused, neither engine can act, and both data streams pass through untouched.

Each engine is a small state machine with three states: `ENG_OFF` (pass-through), `ENG_RAMP` (accumulating ramp) and `ENG_CONST` (fixed word). Every clock edge computes the next state from the engine's 3-bit mode code. Code 001 leads to `ENG_RAMP` and code 010 leads to `ENG_CONST`. Any other code, or an engine that its path flag does not allow, leads to `ENG_OFF`. Every transition among the three states is legal and takes one clock.

Both engines share one 18-bit pattern word. In ramp mode this word is the increment, and in constant mode it is the value. The ramp always accumulates at the full 18-bit width. Each output word is 18 bits wide and left-justified, with the low bits below the chosen resolution forced to zero. A step of one output LSB therefore needs a pre-scaled increment:

| Resolution | Increment for one output LSB |
|---|---|
| 18-bit | 0x00001 |
| 16-bit | 0x00004 |
| 14-bit | 0x00010 |

Top module: `adc_pattern_gen`

## Requirements
- R1: While `dsp_en_i`=1 and `ddc_use_i`=0, `adc_out_o` equals `adc_data_i` and `ddc_out_o` equals `ddc_data_i` in the same cycle, whatever the mode codes are.
- R2: Mode code 001 selects ramp and 010 selects constant. Codes 000 and 011 to 111 select pass-through. Engine 0's code is `ctrl_i[7:5]` and engine 1's code is `ctrl_i[4:2]`.
- R3: Engine 0 may substitute only while `dsp_en_i`=0, and engine 1 only while `ddc_use_i`=1. Dropping the permission returns the path to pass-through in the same cycle. A new mode code takes effect on the output one clock after it is applied.
- R4: In constant state, the output equals the effective pattern word masked to the resolution, and it follows changes of the pattern word in the same cycle. The pattern word is `{ctrl_i[1:0], pat_mid_i, pat_lo_i}`.
- R5: In the first cycle of ramp state, the output is zero. On each later clock in ramp state, the 18-bit accumulator grows by the effective pattern word, and the output shows its top N bits.
- R6: The accumulator wraps modulo 2^18.
- R7: Leaving ramp state, whether through a mode change or through loss of permission, clears the accumulator, so the next ramp starts again from zero.
- R8: `res_sel_i` 00 selects 14 bits, 01 selects 16 bits, 10 selects 18 bits and 11 selects 14 bits. Pattern outputs have every bit below the top N forced to zero.
- R9: Engine 0 uses only the top 14 bits of the pattern word, both as the constant and as the ramp step. Its low 4 pattern bits read as zero.
- R10: During reset, both engines are in `ENG_OFF` with cleared accumulators, and both outputs pass their inputs through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data_i | input | 18 | Raw converter sample, left-justified |
| ddc_data_i | input | 18 | Down-converter output sample, left-justified |
| dsp_en_i | input | 1 | Signal-processing chain enabled |
| ddc_use_i | input | 1 | Down-converter in use |
| res_sel_i | input | 2 | Output resolution select |
| ctrl_i | input | 8 | Engine mode codes and pattern bits 17:16 |
| pat_mid_i | input | 8 | Pattern bits 15:8 |
| pat_lo_i | input | 8 | Pattern bits 7:0 |
| adc_out_o | output | 18 | Raw path output word |
| ddc_out_o | output | 18 | Down-converter path output word |

## Verification
The hardest case to reach is a carry that the output never shows directly. A ramp step with bits below the resolution, or an engine 0 step with bits below the 14-bit window, builds up carries inside the accumulator. Those carries reach the output only after enough cycles have passed. The bench therefore runs long ramps with steps that are not multiples of the output LSB, and with steps large enough to wrap. Every sample is compared with an arithmetic expectation, the step times the cycle index, reduced modulo 2^18 and then masked. Re-entry from zero is reached by removing the permission flag for a single cycle in the middle of a ramp.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ENG_OFF   = 2'd0,
        ENG_RAMP  = 2'd1,
        ENG_CONST = 2'd2
    } eng_state_e;

    localparam logic [2:0] MODE_RAMP  = 3'b001;
    localparam logic [2:0] MODE_CONST = 3'b010;

endpackage

// File: rtl/tpg_cfg_unpack.sv
module tpg_cfg_unpack #(
    parameter int PW     = 18,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 3
) (
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic [BYTE_W-1:0] pat_mid_i,
    input  logic [BYTE_W-1:0] pat_lo_i,
    output logic [PW-1:0]     pat_word_o,
    output logic [MODE_W-1:0] mode_raw_o,
    output logic [MODE_W-1:0] mode_ddc_o
);
    localparam int HI_BITS = PW - 2*BYTE_W;

    // Engine 0 code sits just above engine 1 code, both in the top of the byte.
    assign mode_raw_o = ctrl_i[BYTE_W-1 -: MODE_W];
    assign mode_ddc_o = ctrl_i[BYTE_W-1-MODE_W -: MODE_W];
    assign pat_word_o = {ctrl_i[HI_BITS-1:0], pat_mid_i, pat_lo_i};

endmodule

// File: rtl/tpg_res_mask.sv
module tpg_res_mask #(
    parameter int PW       = 18,
    parameter int RSEL_W   = 2,
    parameter int MIN_RES  = 14,
    parameter int RES_STEP = 2
) (
    input  logic [RSEL_W-1:0] res_sel_i,
    output logic [PW-1:0]     mask_o
);
    localparam int SH_W = $clog2(PW + 1);

    int              keep_bits;
    logic [SH_W-1:0] drop_bits;

    always_comb begin
        unique case (res_sel_i)
            2'd1:    keep_bits = MIN_RES + RES_STEP;
            2'd2:    keep_bits = MIN_RES + 2*RES_STEP;
            default: keep_bits = MIN_RES;
        endcase
        drop_bits = SH_W'(PW - keep_bits);
        mask_o    = {PW{1'b1}} << drop_bits;
    end

endmodule

// File: rtl/tpg_engine.sv
module tpg_engine
    import tpg_pkg::*;
#(
    parameter int PW       = 18,
    parameter int MODE_W   = 3,
    parameter int PAT_KEEP = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [PW-1:0]     pat_word_i,
    input  logic [PW-1:0]     res_mask_i,
    input  logic [PW-1:0]     data_i,
    output logic [PW-1:0]     data_o
);
    localparam logic [PW-1:0] PAT_MASK = {PW{1'b1}} << (PW - PAT_KEEP);

    eng_state_e      state_q, state_d;
    logic [PW-1:0]   acc_q;
    logic [PW-1:0]   eff_pat;
    logic [PW-1:0]   pat_val;

    assign eff_pat = pat_word_i & PAT_MASK;

    // Next-state: every state reaches every state in one clock.
    always_comb begin
        if (!allow_i) begin
            state_d = ENG_OFF;
        end else begin
            unique case (mode_i)
                MODE_RAMP:  state_d = ENG_RAMP;
                MODE_CONST: state_d = ENG_CONST;
                default:    state_d = ENG_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_OFF;
        else        state_q <= state_d;
    end

    // Ramp accumulator: runs only while staying in ramp, cleared otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (state_q == ENG_RAMP && state_d == ENG_RAMP)
            acc_q <= acc_q + eff_pat;
        else
            acc_q <= '0;
    end

    // Output process.
    always_comb begin
        pat_val = '0;
        data_o  = data_i;
        unique case (state_q)
            ENG_RAMP: begin
                pat_val = acc_q & res_mask_i;
                if (allow_i) data_o = pat_val;
            end
            ENG_CONST: begin
                pat_val = eff_pat & res_mask_i;
                if (allow_i) data_o = pat_val;
            end
            default: data_o = data_i;
        endcase
    end

endmodule

// File: rtl/adc_pattern_gen.sv
module adc_pattern_gen #(
    parameter int PW       = 18,
    parameter int BYTE_W   = 8,
    parameter int MODE_W   = 3,
    parameter int RSEL_W   = 2,
    parameter int NARROW_W = 14,
    parameter int MIN_RES  = 14,
    parameter int RES_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     adc_data_i,
    input  logic [PW-1:0]     ddc_data_i,
    input  logic              dsp_en_i,
    input  logic              ddc_use_i,
    input  logic [RSEL_W-1:0] res_sel_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic [BYTE_W-1:0] pat_mid_i,
    input  logic [BYTE_W-1:0] pat_lo_i,
    output logic [PW-1:0]     adc_out_o,
    output logic [PW-1:0]     ddc_out_o
);
    localparam int N_ENG = 2;

    logic [PW-1:0]     pat_word;
    logic [PW-1:0]     res_mask;
    logic [MODE_W-1:0] mode_raw, mode_ddc;

    logic [MODE_W-1:0] eng_mode  [N_ENG];
    logic              eng_allow [N_ENG];
    logic [PW-1:0]     eng_in    [N_ENG];
    logic [PW-1:0]     eng_out   [N_ENG];

    tpg_cfg_unpack #(.PW(PW), .BYTE_W(BYTE_W), .MODE_W(MODE_W)) i_unpack (
        .ctrl_i     (ctrl_i),
        .pat_mid_i  (pat_mid_i),
        .pat_lo_i   (pat_lo_i),
        .pat_word_o (pat_word),
        .mode_raw_o (mode_raw),
        .mode_ddc_o (mode_ddc)
    );

    tpg_res_mask #(.PW(PW), .RSEL_W(RSEL_W), .MIN_RES(MIN_RES), .RES_STEP(RES_STEP)) i_mask (
        .res_sel_i (res_sel_i),
        .mask_o    (res_mask)
    );

    assign eng_mode[0]  = mode_raw;
    assign eng_allow[0] = !dsp_en_i;
    assign eng_in[0]    = adc_data_i;
    assign eng_mode[1]  = mode_ddc;
    assign eng_allow[1] = ddc_use_i;
    assign eng_in[1]    = ddc_data_i;

    // Engine 0 sees only the narrow pattern window; engine 1 the full word.
    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        localparam int KEEP = (g == 0) ? NARROW_W : PW;
        tpg_engine #(.PW(PW), .MODE_W(MODE_W), .PAT_KEEP(KEEP)) i_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .allow_i    (eng_allow[g]),
            .mode_i     (eng_mode[g]),
            .pat_word_i (pat_word),
            .res_mask_i (res_mask),
            .data_i     (eng_in[g]),
            .data_o     (eng_out[g])
        );
    end

    assign adc_out_o = eng_out[0];
    assign ddc_out_o = eng_out[1];

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int PW       = 18,
    parameter int BYTE_W   = 8,
    parameter int MODE_W   = 3,
    parameter int RSEL_W   = 2,
    parameter int NARROW_W = 14,
    parameter int MIN_RES  = 14,
    parameter int RES_STEP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PW-1:0]     adc_data_i,
    input logic [PW-1:0]     ddc_data_i,
    input logic              dsp_en_i,
    input logic              ddc_use_i,
    input logic [RSEL_W-1:0] res_sel_i,
    input logic [BYTE_W-1:0] ctrl_i,
    input logic [BYTE_W-1:0] pat_mid_i,
    input logic [BYTE_W-1:0] pat_lo_i,
    input logic [PW-1:0]     adc_out_o,
    input logic [PW-1:0]     ddc_out_o
);
    logic [MODE_W-1:0] m0, m1;
    logic [PW-1:0]     pw, win0, rmask;
    logic              raw_const, raw_active, ddc_ramp;

    assign m0   = ctrl_i[7:5];
    assign m1   = ctrl_i[4:2];
    assign pw   = {ctrl_i[1:0], pat_mid_i, pat_lo_i};
    assign win0 = pw & 18'h3FFF0;
    assign rmask = (res_sel_i == 2'd1) ? 18'h3FFFC :
                   (res_sel_i == 2'd2) ? 18'h3FFFF : 18'h3FFF0;
    assign raw_const  = !dsp_en_i && m0 == 3'b010;
    assign raw_active = !dsp_en_i && (m0 == 3'b001 || m0 == 3'b010);
    assign ddc_ramp   = ddc_use_i && m1 == 3'b001;

    // R1
    bypass_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_en_i && !ddc_use_i) |-> (adc_out_o == adc_data_i && ddc_out_o == ddc_data_i));

    // R2
    raw_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(raw_active) |-> adc_out_o == adc_data_i);

    // R9
    raw_const_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(raw_const) && !dsp_en_i) |-> adc_out_o == (win0 & rmask));

    // R5
    ramp_starts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ddc_ramp) && !$past(ddc_ramp, 2) && ddc_use_i)
        |-> ddc_out_o == '0);

    // R6
    ramp_full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(ddc_ramp) && $past(ddc_ramp, 2) && ddc_use_i
         && res_sel_i == 2'd2 && $past(res_sel_i) == 2'd2)
        |-> ddc_out_o == PW'($past(ddc_out_o) + $past(pw)));

endmodule

bind adc_pattern_gen tpg_checker #(
    .PW(PW), .BYTE_W(BYTE_W), .MODE_W(MODE_W), .RSEL_W(RSEL_W),
    .NARROW_W(NARROW_W), .MIN_RES(MIN_RES), .RES_STEP(RES_STEP)
) i_chk (.*);

// File: tb/test_adc_pattern_gen.sv
`timescale 1ns/1ps
module test_adc_pattern_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] adc_data_i, ddc_data_i;
    logic        dsp_en_i, ddc_use_i;
    logic [1:0]  res_sel_i;
    logic [7:0]  ctrl_i, pat_mid_i, pat_lo_i;
    logic [17:0] adc_out_o, ddc_out_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adc_pattern_gen i_adc_pattern_gen (.*);

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] mask_of(input int sel);
        int keep;
        keep = (sel == 1) ? 16 : (sel == 2) ? 18 : 14;
        return 18'h3FFFF << (18 - keep);
    endfunction

    task automatic drive(input logic [2:0] m0, input logic [2:0] m1, input logic [17:0] p);
        ctrl_i    = {m0, m1, p[17:16]};
        pat_mid_i = p[15:8];
        pat_lo_i  = p[7:0];
    endtask

    // Runs a ramp on one engine and compares n samples with k*step.
    task automatic ramp_run(input string req, input int eng, input logic [17:0] step,
                            input int sel, input int n);
        logic [17:0] eff;
        @(negedge clk);
        dsp_en_i  = (eng == 0) ? 1'b0 : 1'b1;
        ddc_use_i = (eng == 1);
        res_sel_i = 2'(sel);
        drive(3'b000, 3'b000, step);
        @(negedge clk);
        drive(eng == 0 ? 3'b001 : 3'b000, eng == 1 ? 3'b001 : 3'b000, step);
        eff = (eng == 0) ? (step & 18'h3FFF0) : step;
        for (int k = 0; k < n; k++) begin
            logic [47:0] prod;
            @(negedge clk);
            prod = 48'(k) * 48'(eff);
            chk(req, eng == 0 ? adc_out_o : ddc_out_o, prod[17:0] & mask_of(sel));
        end
    endtask

    initial begin
        #(64'd200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        adc_data_i = 18'h2A5A5; ddc_data_i = 18'h15A5A;
        dsp_en_i = 1'b0; ddc_use_i = 1'b1; res_sel_i = 2'd2;
        drive(3'b001, 3'b010, 18'h12345);
        repeat (3) @(negedge clk);
        // R10: reset holds both paths in pass-through
        chk("R10", adc_out_o, adc_data_i);
        chk("R10", ddc_out_o, ddc_data_i);
        rst_n = 1'b1;

        // R1: bypass for every mode pair
        dsp_en_i = 1'b1; ddc_use_i = 1'b0;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                drive(3'(a), 3'(b), 18'h3C3C3);
                adc_data_i = 18'(a * 4111 + b);
                ddc_data_i = 18'(b * 7919 + a);
                @(negedge clk);
                chk("R1", adc_out_o, adc_data_i);
                chk("R1", ddc_out_o, ddc_data_i);
            end
        end

        // R2: unused codes act as pass-through on both engines
        dsp_en_i = 1'b0; ddc_use_i = 1'b1;
        for (int m = 0; m < 8; m++) begin
            if (m == 1 || m == 2) continue;
            @(negedge clk);
            drive(3'(m), 3'(m), 18'h2FFFF);
            @(negedge clk);
            @(negedge clk);
            chk("R2", adc_out_o, adc_data_i);
            chk("R2", ddc_out_o, ddc_data_i);
        end

        // R4 R8 R9: constant sweep over resolutions and patterns
        for (int sel = 0; sel < 4; sel++) begin
            for (int p = 0; p < 6; p++) begin
                logic [17:0] pv;
                pv = 18'((p * 18'h0B6DB) ^ 18'h1F00F);
                @(negedge clk);
                res_sel_i = 2'(sel);
                drive(3'b010, 3'b010, pv);
                @(negedge clk);
                chk("R4/R8", ddc_out_o, pv & mask_of(sel));
                chk("R9", adc_out_o, pv & 18'h3FFF0 & mask_of(sel));
            end
        end
        // R4: constant follows pattern change within the cycle
        @(negedge clk);
        res_sel_i = 2'd2;
        drive(3'b010, 3'b010, 18'h0000F);
        #2;
        chk("R4", ddc_out_o, 18'h0000F);
        chk("R9", adc_out_o, 18'h00000);

        // R3: permission loss is immediate, mode takes a clock
        @(negedge clk);
        dsp_en_i = 1'b1; ddc_use_i = 1'b0;
        #2;
        chk("R3", adc_out_o, adc_data_i);
        chk("R3", ddc_out_o, ddc_data_i);
        @(negedge clk);
        dsp_en_i = 1'b0; ddc_use_i = 1'b1;
        drive(3'b000, 3'b000, 18'h11111);
        @(negedge clk);
        drive(3'b010, 3'b010, 18'h11111);
        #2;
        chk("R3", adc_out_o, adc_data_i);
        chk("R3", ddc_out_o, ddc_data_i);
        @(negedge clk);
        chk("R3", ddc_out_o, 18'h11111);

        // R5 R8 R9: ramps at every resolution
        for (int sel = 0; sel < 4; sel++) begin
            ramp_run("R5", 1, 18'h00001, sel, 20);
            ramp_run("R5", 1, 18'h00004, sel, 20);
            ramp_run("R5", 1, 18'h00123, sel, 24);
            ramp_run("R9", 0, 18'h00010, sel, 20);
            ramp_run("R9", 0, 18'h0012F, sel, 24);
        end

        // R6: wrap modulo 2^18
        ramp_run("R6", 1, 18'h30001, 2, 12);
        ramp_run("R6", 0, 18'h2FFF7, 0, 12);

        // R7: losing permission for one cycle clears the accumulator
        ramp_run("R7", 1, 18'h00005, 2, 6);
        ddc_use_i = 1'b0;
        @(negedge clk);
        chk("R7", ddc_out_o, ddc_data_i);
        ddc_use_i = 1'b1;
        @(negedge clk);
        chk("R7", ddc_out_o, 18'h00000);
        @(negedge clk);
        chk("R7", ddc_out_o, 18'h00005);
        // R7: a detour through constant also restarts from zero
        drive(3'b000, 3'b010, 18'h00005);
        @(negedge clk);
        chk("R7", ddc_out_o, 18'h00005);
        drive(3'b000, 3'b001, 18'h00005);
        @(negedge clk);
        chk("R7", ddc_out_o, 18'h00000);
        @(negedge clk);
        chk("R7", ddc_out_o, 18'h00005);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule